// File: doc/BRIEF.md
# Gated Signal Measurement Timer

This block is a 24-bit measurement counter that advances on a prescaled tick derived from one of several source inputs. In gated-counter operation the counter steps only while the polarity-corrected measured signal is active. The two edges of that signal snapshot the counter into two capture registers: one for pulse width and one for period. A programmable compare value bounds the count. When the counter equals it, the next counting step wraps the counter to zero and sets an interrupt flag. An optional halt setting instead freezes the counter on the compare value and keeps the flag raised.

Software-style strobes control the block. They can zero the counter, load it while the timer is stopped, copy it into either capture register, and clear the interrupt flag. The measured signal and a window input pass through a two-flop synchronizer and are then resampled on each prescaled tick. The resampled, polarity-corrected levels are presented as status bits while the timer runs.

Top module: `sig_meas_timer`

## Requirements
- R1: After reset, `tmr`, `cpw`, `cpr`, `irq_flag`, `sig_stat` and `win_stat` are all zero.
- R2: With `go`=1 and the corrected signal (`sig_in` XOR `sig_pol`) active, `tmr` rises by one on each prescaled tick. It holds while the corrected signal is inactive and while `go`=0.
- R3: `ps_sel` value n (0..3) gives one prescaled tick for every 2^n qualifying source edges counted from reset.
- R4: `src_sel` picks bit `src_lvl[src_sel]`. With `clk_pol`=0 its rising edges qualify, and with `clk_pol`=1 its falling edges qualify.
- R5: A counting step taken while `tmr` equals `period` (halt off) sets `tmr` to 0 and sets `irq_flag`.
- R6: With `halt_en`=1, a counting step at `tmr`==`period` leaves `tmr` unchanged and sets `irq_flag`. While `tmr`==`period`, `irq_clr` has no effect.
- R7: When the R6 condition does not hold, a one-cycle `irq_clr` pulse clears `irq_flag` on the next clock.
- R8: `tmr_clr` zeroes `tmr` on the next clock and takes priority over writes and counting.
- R9: `cpw_upd` copies the current `tmr` into `cpw`, and `cpr_upd` copies it into `cpr`.
- R10: On the first tick at which the corrected signal is seen active after being inactive, `cpw` takes the pre-step `tmr`. On the first tick at which it is seen inactive, `cpr` takes `tmr`.
- R11: `sig_stat` and `win_stat` show the corrected `sig_in` and `win_in` levels as last sampled on a prescaled tick while `go`=1. Both read 0 while `go`=0.
- R12: `tmr_we` loads `tmr_wdata` into `tmr` only while `go`=0 and is ignored while `go`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Timer run enable |
| halt_en | input | 1 | Freeze at compare match instead of wrapping |
| ps_sel | input | 2 | Prescaler code, divide by 2^code |
| clk_pol | input | 1 | Source edge select, 0 rising, 1 falling |
| sig_pol | input | 1 | Measured-signal polarity, 1 inverts |
| win_pol | input | 1 | Window polarity, 1 inverts |
| src_sel | input | 2 | Tick source index |
| src_lvl | input | 4 | Tick source levels |
| sig_in | input | 1 | Measured signal pin |
| win_in | input | 1 | Window pin |
| period | input | 24 | Compare value |
| tmr_we | input | 1 | Counter write strobe |
| tmr_wdata | input | 24 | Counter write data |
| tmr_clr | input | 1 | Counter zero strobe |
| cpw_upd | input | 1 | Copy counter to pulse-width capture |
| cpr_upd | input | 1 | Copy counter to period capture |
| irq_clr | input | 1 | Write-one-to-clear for the flag |
| tmr | output | 24 | Counter value |
| cpw | output | 24 | Pulse-width capture |
| cpr | output | 24 | Period capture |
| irq_flag | output | 1 | Period-match flag |
| sig_stat | output | 1 | Corrected signal status |
| win_stat | output | 1 | Corrected window status |

## Verification
The bench builds the block with its default parameters: a 24-bit counter and four tick sources. It sweeps every prescaler code, both source-edge polarities and two source indices, and compares the counter against the quotient of edges over 2^code. Compare values of 3 and 5 bring the wrap and halt corners within a few ticks. Directed sequences cover the edge captures, the strobes, write gating and status polarity.

// File: rtl/smt_pkg.sv
package smt_pkg;

    localparam int PS_W  = 2;
    localparam int PDIV_W = 3;

    typedef enum logic [PS_W-1:0] {
        PS_DIV1 = 2'd0,
        PS_DIV2 = 2'd1,
        PS_DIV4 = 2'd2,
        PS_DIV8 = 2'd3
    } ps_code_e;

    // Per-channel view of a synchronized input at a prescaled tick.
    typedef struct packed {
        logic now;   // corrected level presented at this tick
        logic held;  // level latched at the previous running tick
        logic rise;  // became active at this tick
        logic fall;  // became inactive at this tick
    } chan_view_t;

    // Low bits of the edge counter that must all be set for a tick.
    function automatic logic [PDIV_W-1:0] ps_mask(input ps_code_e code);
        logic [PDIV_W-1:0] m;
        m = '0;
        for (int i = 0; i < PDIV_W; i++) begin
            if (i < int'(code)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/smt_tick_gen.sv
module smt_tick_gen
    import smt_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_lvl,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic              clk_pol,
    input  ps_code_e          ps_sel,
    output logic              ptick
);

    logic              lvl_now;
    logic              lvl_prev;
    logic              src_edge;
    logic [PDIV_W-1:0] edge_cnt;
    logic [PDIV_W-1:0] mask;

    assign lvl_now  = src_lvl[src_sel];
    assign src_edge = clk_pol ? (~lvl_now & lvl_prev) : (lvl_now & ~lvl_prev);
    assign mask     = ps_mask(ps_sel);
    assign ptick    = src_edge && ((edge_cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev <= 1'b0;
            edge_cnt <= '0;
        end else begin
            lvl_prev <= lvl_now;
            if (src_edge) edge_cnt <= edge_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/smt_in_sync.sv
module smt_in_sync
    import smt_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pin,
    input  logic [NCH-1:0] pol,
    input  logic           run_tick,
    output chan_view_t     view [NCH]
);

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        logic s1, s2, held;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1   <= 1'b0;
                s2   <= 1'b0;
                held <= 1'b0;
            end else begin
                s1 <= pin[gi] ^ pol[gi];
                s2 <= s1;
                if (run_tick) held <= s2;
            end
        end

        always_comb begin
            view[gi].now  = s2;
            view[gi].held = held;
            view[gi].rise = run_tick & s2 & ~held;
            view[gi].fall = run_tick & ~s2 & held;
        end
    end

endmodule

// File: rtl/smt_counter.sv
module smt_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             halt_en,
    input  logic [CNT_W-1:0] period,
    input  logic             step,
    input  logic             cap_w,
    input  logic             cap_p,
    input  logic             tmr_clr,
    input  logic             tmr_we,
    input  logic [CNT_W-1:0] tmr_wdata,
    input  logic             cpw_upd,
    input  logic             cpr_upd,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] tmr,
    output logic [CNT_W-1:0] cpw,
    output logic [CNT_W-1:0] cpr,
    output logic             irq_flag
);

    logic match;
    logic sticky;

    assign match  = (tmr == period);
    assign sticky = halt_en & match;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr      <= '0;
            cpw      <= '0;
            cpr      <= '0;
            irq_flag <= 1'b0;
        end else begin
            if (tmr_clr)           tmr <= '0;
            else if (tmr_we && !go) tmr <= tmr_wdata;
            else if (step) begin
                if (!match)        tmr <= tmr + 1'b1;
                else if (!halt_en) tmr <= '0;
            end

            if (cpw_upd)    cpw <= tmr;
            else if (cap_w) cpw <= tmr;

            if (cpr_upd)    cpr <= tmr;
            else if (cap_p) cpr <= tmr;

            if (step && match)          irq_flag <= 1'b1;
            else if (irq_clr && !sticky) irq_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/sig_meas_timer.sv
module sig_meas_timer
    import smt_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int NSRC  = 4,
    parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             halt_en,
    input  logic [1:0]       ps_sel,
    input  logic             clk_pol,
    input  logic             sig_pol,
    input  logic             win_pol,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [NSRC-1:0]  src_lvl,
    input  logic             sig_in,
    input  logic             win_in,
    input  logic [CNT_W-1:0] period,
    input  logic             tmr_we,
    input  logic [CNT_W-1:0] tmr_wdata,
    input  logic             tmr_clr,
    input  logic             cpw_upd,
    input  logic             cpr_upd,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] tmr,
    output logic [CNT_W-1:0] cpw,
    output logic [CNT_W-1:0] cpr,
    output logic             irq_flag,
    output logic             sig_stat,
    output logic             win_stat
);

    localparam int CH_SIG = 0;
    localparam int CH_WIN = 1;
    localparam int NCH    = 2;

    logic       ptick;
    logic       run_tick;
    logic       sig_now;
    chan_view_t view [NCH];

    smt_tick_gen #(.NSRC(NSRC), .SEL_W(SEL_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .src_lvl (src_lvl),
        .src_sel (src_sel),
        .clk_pol (clk_pol),
        .ps_sel  (ps_code_e'(ps_sel)),
        .ptick   (ptick)
    );

    assign run_tick = ptick & go;

    smt_in_sync #(.NCH(NCH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin      ({win_in, sig_in}),
        .pol      ({win_pol, sig_pol}),
        .run_tick (run_tick),
        .view     (view)
    );

    assign sig_now = view[CH_SIG].now;

    smt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .halt_en   (halt_en),
        .period    (period),
        .step      (run_tick & sig_now),
        .cap_w     (view[CH_SIG].rise),
        .cap_p     (view[CH_SIG].fall),
        .tmr_clr   (tmr_clr),
        .tmr_we    (tmr_we),
        .tmr_wdata (tmr_wdata),
        .cpw_upd   (cpw_upd),
        .cpr_upd   (cpr_upd),
        .irq_clr   (irq_clr),
        .tmr       (tmr),
        .cpw       (cpw),
        .cpr       (cpr),
        .irq_flag  (irq_flag)
    );

    assign sig_stat = go & view[CH_SIG].held;
    assign win_stat = go & view[CH_WIN].held;

endmodule

// File: rtl/sig_meas_timer_chk.sv
module sig_meas_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             go,
    input logic             halt_en,
    input logic             tick,
    input logic             act,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] tmr,
    input logic             irq_flag,
    input logic             tmr_clr,
    input logic             tmr_we
);

    p_clr_zero_r8: assert property (@(posedge clk) disable iff (rst)
        tmr_clr |=> (tmr == '0));

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && go && act && (tmr == period) && !halt_en && !tmr_clr)
        |=> ((tmr == '0) && irq_flag));

    p_halt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (halt_en && (tmr == period) && irq_flag && !tmr_clr && !(tmr_we && !go))
        |=> irq_flag);

    p_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        (go && !tick && !tmr_clr) |=> $stable(tmr));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && go && act && (tmr != period) && !tmr_clr)
        |=> (tmr == CNT_W'($past(tmr) + 1)));

endmodule

bind sig_meas_timer sig_meas_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .halt_en  (halt_en),
    .tick     (ptick),
    .act      (sig_now),
    .period   (period),
    .tmr      (tmr),
    .irq_flag (irq_flag),
    .tmr_clr  (tmr_clr),
    .tmr_we   (tmr_we)
);

// File: tb/sig_meas_timer_test.sv
module sig_meas_timer_test;

    logic        clk = 1'b0;
    logic        rst, go, halt_en, clk_pol, sig_pol, win_pol;
    logic [1:0]  ps_sel, src_sel;
    logic [3:0]  src_lvl;
    logic        sig_in, win_in, tmr_we, tmr_clr, cpw_upd, cpr_upd, irq_clr;
    logic [23:0] period, tmr_wdata, tmr, cpw, cpr;
    logic        irq_flag, sig_stat, win_stat;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sig_meas_timer uut (
        .clk(clk), .rst(rst), .go(go), .halt_en(halt_en), .ps_sel(ps_sel),
        .clk_pol(clk_pol), .sig_pol(sig_pol), .win_pol(win_pol),
        .src_sel(src_sel), .src_lvl(src_lvl), .sig_in(sig_in), .win_in(win_in),
        .period(period), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
        .tmr_clr(tmr_clr), .cpw_upd(cpw_upd), .cpr_upd(cpr_upd),
        .irq_clr(irq_clr), .tmr(tmr), .cpw(cpw), .cpr(cpr),
        .irq_flag(irq_flag), .sig_stat(sig_stat), .win_stat(win_stat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulse the currently selected source once: one rising and one falling edge.
    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); src_lvl[src_sel] = 1'b1;
            @(negedge clk); src_lvl[src_sel] = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic strobe_clr_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; go = 1'b0; src_lvl = '0;
        tmr_we = 0; tmr_clr = 0; cpw_upd = 0; cpr_upd = 0; irq_clr = 0;
        clks(2);
        rst = 1'b0;
        clks(3);
    endtask

    initial begin
        rst = 1; go = 0; halt_en = 0; clk_pol = 0; sig_pol = 0; win_pol = 0;
        ps_sel = 0; src_sel = 0; src_lvl = 0; sig_in = 0; win_in = 0;
        period = 24'hFFFFFF; tmr_we = 0; tmr_wdata = 0; tmr_clr = 0;
        cpw_upd = 0; cpr_upd = 0; irq_clr = 0;
        do_reset();

        // R1 reset state
        check("R1 tmr", tmr, 0);
        check("R1 cpw", cpw, 0);
        check("R1 cpr", cpr, 0);
        check("R1 irq", irq_flag, 0);
        check("R1 stat", {sig_stat, win_stat}, 0);

        // R2 R3 R4 sweep: prescaler x source edge polarity x source index
        for (int ps = 0; ps < 4; ps++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int s = 0; s < 2; s++) begin
                    ps_sel = 2'(ps); clk_pol = pol[0]; src_sel = 2'(s * 2);
                    sig_pol = 0; sig_in = 1; period = 24'hFFFFFF;
                    do_reset();
                    go = 1;
                    pulse(20);
                    check($sformatf("R3 R4 R2 ps=%0d pol=%0d src=%0d", ps, pol, s * 2),
                          tmr, 32'(20 >> ps));
                end
            end
        end

        // R2 counting held while the signal is inactive, and while go=0
        ps_sel = 0; clk_pol = 0; src_sel = 1; sig_in = 1;
        do_reset();
        go = 1; pulse(4);
        sig_in = 0; clks(3); pulse(5);
        check("R2 inactive hold", tmr, 4);
        sig_in = 1; clks(3); go = 0; pulse(3);
        check("R2 go low hold", tmr, 4);

        // R12 write ignored while running, accepted when stopped
        go = 1; @(negedge clk); tmr_we = 1; tmr_wdata = 24'd77;
        @(negedge clk); tmr_we = 0; clks(1);
        check("R12 write while go", tmr, 4);
        go = 0; @(negedge clk); tmr_we = 1;
        @(negedge clk); tmr_we = 0;
        check("R12 write stopped", tmr, 77);

        // R9 software copies
        @(negedge clk); cpw_upd = 1; @(negedge clk); cpw_upd = 0;
        check("R9 cpw copy", cpw, 77);
        @(negedge clk); cpr_upd = 1; @(negedge clk); cpr_upd = 0;
        check("R9 cpr copy", cpr, 77);

        // R5 wrap and R7 clear
        period = 5; sig_in = 1;
        do_reset();
        go = 1; pulse(5);
        check("R5 at match", tmr, 5);
        check("R5 no irq yet", irq_flag, 0);
        pulse(1);
        check("R5 wrapped", tmr, 0);
        check("R5 irq set", irq_flag, 1);
        strobe_clr_irq();
        check("R7 irq cleared", irq_flag, 0);
        pulse(3);
        check("R5 counts after wrap", tmr, 3);

        // R6 halt: sticky flag, then R8 clear
        period = 3; halt_en = 1;
        do_reset();
        go = 1; pulse(6);
        check("R6 held at match", tmr, 3);
        check("R6 irq set", irq_flag, 1);
        strobe_clr_irq();
        check("R6 irq sticky", irq_flag, 1);
        @(negedge clk); tmr_clr = 1; @(negedge clk); tmr_clr = 0;
        check("R8 clear", tmr, 0);
        strobe_clr_irq();
        check("R7 irq cleared after reset", irq_flag, 0);
        halt_en = 0;

        // R8 priority over counting and writes
        period = 24'hFFFFFF;
        @(negedge clk); tmr_we = 1; tmr_wdata = 9; tmr_clr = 1;
        @(negedge clk); tmr_we = 0; tmr_clr = 0;
        check("R8 priority", tmr, 0);

        // R10 edge captures
        sig_in = 0;
        do_reset();
        @(negedge clk); tmr_we = 1; tmr_wdata = 10; @(negedge clk); tmr_we = 0;
        go = 1; pulse(2);
        check("R10 no count inactive", tmr, 10);
        sig_in = 1; clks(3); pulse(4);
        check("R10 cpw at rise", cpw, 10);
        check("R10 count active", tmr, 14);
        sig_in = 0; clks(3); pulse(2);
        check("R10 cpr at fall", cpr, 14);
        check("R10 cpw unchanged", cpw, 10);

        // R11 status polarity and gating
        sig_pol = 1; sig_in = 0; win_pol = 0; win_in = 1;
        do_reset();
        check("R11 stat stopped", {sig_stat, win_stat}, 0);
        go = 1; clks(1);
        check("R11 stat before tick", {sig_stat, win_stat}, 0);
        pulse(1);
        check("R11 stat corrected", {sig_stat, win_stat}, 2'b11);
        sig_in = 1; win_in = 0; clks(3); pulse(1);
        check("R11 stat follows", {sig_stat, win_stat}, 2'b00);
        sig_in = 0; win_in = 1; clks(3); pulse(1);
        go = 0; clks(1);
        check("R11 stat gated by go", {sig_stat, win_stat}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule